// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32768 bytes. The host hands over one word per request on a valid/ready interface. The block turns each request into a sequence of active-low chip-select, write-enable and output-enable strobes. It also drives a 15-bit address and a split 8-bit data bus: data out, data in and a drive enable for the pad tri-state. Read data comes back with a single-cycle response strobe.

Every strobe leaves a flop. The length of each phase comes from the memory's nanosecond limits, rounded up to whole clock periods. The sequencing follows three rules. The address never moves while a write overlap is open. Output enable stays high for every write, so the short write-pulse rule applies. The controller drives the bus only when the memory cannot be driving it, and it leaves a gap after each read before the next drive.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request pending: chip select, write enable and output enable are all high (inactive), the bus drive enable is low, req_ready_o is high and rsp_valid_o is low.
- R2: The memory address changes only when a request is accepted, and never while chip select and write enable are both low.
- R3: Write enable goes low only while chip select is low and output enable is high. The byte on the bus is stored at the address during that overlap, and a later read of the same address returns it.
- R4: A write opens with exactly one setup cycle (chip select low, write enable high). Write enable then stays low for exactly WP_EFF cycles, where WP_EFF is the larger of the write-pulse and data-setup cycle counts.
- R5: The data bus is driven with the request's write byte, unchanged, from the setup cycle up to and including the cycle after write enable rises.
- R6: The bus drive enable is never high while output enable is low, nor in the cycle in which output enable has just risen.
- R7: Chip select is high in every cycle in which no access is in progress. It rises at the end of each access.
- R8: A read holds chip select and output enable low for RD_CYC cycles and samples the bus on the last of them. The sampled byte appears on rsp_rdata_o with rsp_valid_o high for exactly one cycle, the cycle after sampling. Writes give no response pulse.
- R9: req_ready_o is low from the cycle after acceptance until the access ends. A write keeps it low for 2+WP_EFF cycles and a read for RD_CYC+TA_CYC cycles.
- R10: Each cycle count is the nanosecond (picosecond parameter) limit divided by the clock period and rounded up, with a minimum of one cycle. A zero turnaround limit therefore still gives a one-cycle gap after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle; request accepted when both high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 15 | Memory address |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The bench uses a cycle model of the memory. The model keeps driving the bus for one cycle after output enable rises and stores a byte only when a write overlap closes. It flags a moving address, a short pulse, unstable data and bus contention.

A fixed table mixes isolated writes and reads, and the checks tell a storage fault apart from a sequencing fault. The table includes boundary addresses 0 and 0x7FFF, a read straight after a write to the same address, and a write straight after a read. The write-after-read case exposes a missing turnaround gap as contention. A random run of writes and reads over a small address set then checks that data is not lost across unrelated accesses. Per-access cycle counts separate a wrong pulse length from a wrong response timing.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_R_TURN
  } ctrl_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  // cnt counts remaining cycles after the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  p_load_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rsp_valid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o      = addr_q;
  assign dq_o        = wdata_q;
  assign rdata_o     = rdata_q;
  assign rsp_valid_o = rsp_q;

  p_addr_on_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_o));

  p_wdata_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(dq_o));

  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_AA_PS       = 10000,
  parameter int unsigned T_WP_PS       = 9000,
  parameter int unsigned T_DW_PS       = 6000,
  parameter int unsigned T_OHZ_PS      = 6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC  = ps_to_cycles(T_AA_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_CYC  = ps_to_cycles(T_WP_PS, CLK_PERIOD_PS);
  localparam int unsigned DW_CYC  = ps_to_cycles(T_DW_PS, CLK_PERIOD_PS);
  localparam int unsigned TA_CYC  = ps_to_cycles(T_OHZ_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_EFF  = max2(WP_CYC, DW_CYC);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_EFF), TA_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e      state_q, state_d;
  strobe_t          strb_q, strb_d;
  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_we_i) begin
            state_d = ST_W_SETUP;
          end else begin
            state_d  = ST_R_ACCESS;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC);
          end
        end
      end
      ST_W_SETUP: begin
        state_d  = ST_W_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_EFF);
      end
      ST_W_PULSE: if (tmr_last) state_d = ST_W_HOLD;
      ST_W_HOLD:  state_d = ST_IDLE;
      ST_R_ACCESS: begin
        if (tmr_last) begin
          capture  = 1'b1;
          state_d  = ST_R_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TA_CYC);
        end
      end
      ST_R_TURN: if (tmr_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // strobes decoded from the next state and registered: glitch-free pins
  always_comb begin
    strb_d = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    unique case (state_d)
      ST_W_SETUP:  strb_d = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_W_PULSE:  strb_d = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_W_HOLD:   strb_d = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_R_ACCESS: strb_d = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:     strb_d = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      strb_q  <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .capture_i   (capture),
    .dq_i        (mem_dq_i),
    .addr_o      (mem_addr_o),
    .dq_o        (mem_dq_o),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_cs_n_o  = strb_q.cs_n;
  assign mem_we_n_o  = strb_q.we_n;
  assign mem_oe_n_o  = strb_q.oe_n;
  assign mem_dq_oe_o = strb_q.dq_oe;

  // write-pulse length tracker for p_wp_len_r4
  logic [CNT_W:0] we_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_q <= '0;
    else if (!mem_we_n_o) we_low_q <= we_low_q + 1'b1;
    else                  we_low_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && !mem_we_n_o) |=> $stable(mem_addr_o));

  p_we_needs_cs_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_oe_n_o));

  p_wp_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_low_q == (CNT_W+1)'(WP_EFF)));

  p_setup_before_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> $past(!mem_cs_n_o && mem_dq_oe_o));

  p_drive_in_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_dq_oe_o);

  p_drive_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> mem_dq_oe_o);

  p_no_drive_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !mem_dq_oe_o);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> !mem_dq_oe_o);

  p_cs_off_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> mem_cs_n_o);

  p_rsp_only_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_oe_n_o));

  p_busy_no_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(mem_addr_o));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int unsigned WP_EFF = 2;  // ceil(15000/10000)
  localparam int unsigned RD_CYC = 2;  // ceil(20000/10000)
  localparam int unsigned TA_CYC = 1;  // 0 ps rounds up to minimum 1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        cs_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  always #5 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(15), .DATA_W(8), .CLK_PERIOD_PS(10000),
    .T_AA_PS(20000), .T_WP_PS(15000), .T_DW_PS(8000), .T_OHZ_PS(0)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n), .mem_we_n_o(we_n),
    .mem_oe_n_o(oe_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // ---------------- memory model ----------------
  logic [7:0] mdl_mem [0:32767];
  logic [7:0] ref_mem [0:32767];
  int addr_viol = 0, cont_viol = 0, time_viol = 0, oe_viol = 0, idle_viol = 0;
  logic        prev_drv = 1'b0, prev_ovl = 1'b0, prev_dq_oe = 1'b0;
  logic [14:0] prev_addr = '0;
  int          ovl_len = 0;
  logic        dstable = 1'b0;
  logic [7:0]  wbyte = '0;

  assign dq_i = (!cs_n && we_n && !oe_n) ? mdl_mem[mem_addr] : 8'h00;

  always @(negedge clk) begin
    logic drv, hold, ovl;
    if (rst_n) begin
      drv  = !cs_n && we_n && !oe_n;
      hold = prev_drv && !drv;  // memory releases one cycle late
      ovl  = !cs_n && !we_n;
      if ((drv || hold) && dq_oe) cont_viol++;
      if (ovl && prev_ovl && mem_addr != prev_addr) addr_viol++;
      if (ovl && !oe_n) oe_viol++;
      if (ovl && !prev_ovl) begin
        ovl_len = 0; dstable = 1'b1; wbyte = dq_o;
        if (!prev_dq_oe) time_viol++;
      end
      if (ovl) begin
        ovl_len++;
        if (!dq_oe || dq_o != wbyte) dstable = 1'b0;
      end
      if (!ovl && prev_ovl) begin
        if (ovl_len < int'(WP_EFF) || !dstable || !dq_oe) time_viol++;
        mdl_mem[prev_addr] = wbyte;
      end
      if (req_ready && !cs_n) idle_viol++;
      prev_drv = drv; prev_ovl = ovl; prev_addr = mem_addr; prev_dq_oe = dq_oe;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int n_tests = 0, n_fail = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic do_access(input logic we, input logic [14:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int lat, output int nrsp,
                           output int we_low, output int oe_low);
    rd = '0; lat = 0; nrsp = 0; we_low = 0; oe_low = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;  // must not affect the write in flight
    while (!req_ready) begin
      lat++;
      if (rsp_valid) begin nrsp++; rd = rsp_rdata; end
      if (!we_n) we_low++;
      if (!oe_n) oe_low++;
      @(negedge clk);
    end
    if (rsp_valid) nrsp++;  // a late pulse would be counted as extra
  endtask

  task automatic access_checked(input logic we, input logic [14:0] a, input logic [7:0] d);
    logic [7:0] rd;
    int lat, nrsp, wl, ol;
    do_access(we, a, d, rd, lat, nrsp, wl, ol);
    if (we) begin
      ref_mem[a] = d;
      check(lat == int'(2 + WP_EFF), "R9 write busy cycles", lat, 2 + WP_EFF);
      check(wl == int'(WP_EFF), "R4 write pulse cycles", wl, WP_EFF);
      check(nrsp == 0, "R8 no response on write", nrsp, 0);
    end else begin
      check(rd == ref_mem[a], "R3 R8 read data", rd, ref_mem[a]);
      check(lat == int'(RD_CYC + TA_CYC), "R9 R10 read busy cycles", lat, RD_CYC + TA_CYC);
      check(ol == int'(RD_CYC), "R8 output enable cycles", ol, RD_CYC);
      check(nrsp == 1, "R8 single response pulse", nrsp, 1);
    end
  endtask

  // {we, addr, data}
  localparam logic [23:0] VEC [0:13] = '{
    {1'b1, 15'h0000, 8'hA5},
    {1'b1, 15'h7FFF, 8'h3C},
    {1'b0, 15'h0000, 8'h00},
    {1'b0, 15'h7FFF, 8'h00},
    {1'b1, 15'h1234, 8'hFF},
    {1'b0, 15'h1234, 8'h00},
    {1'b1, 15'h1234, 8'h00},
    {1'b0, 15'h1234, 8'h00},
    {1'b0, 15'h0555, 8'h00},
    {1'b1, 15'h0555, 8'h81},
    {1'b1, 15'h0556, 8'h7E},
    {1'b0, 15'h0555, 8'h00},
    {1'b0, 15'h0556, 8'h00},
    {1'b1, 15'h0000, 8'h5A}
  };

  initial begin
    for (int i = 0; i < 32768; i++) begin mdl_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cs_n && we_n && oe_n, "R1 strobes high in reset", {cs_n, we_n, oe_n}, 7);
    check(!dq_oe, "R1 no drive in reset", dq_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid, "R1 ready idle after reset", {req_ready, rsp_valid}, 2);
    check(cs_n, "R7 standby when idle", cs_n, 1);

    for (int i = 0; i < 14; i++)
      access_checked(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);

    // random traffic over a small address set
    for (int i = 0; i < 200; i++) begin
      logic [14:0] a;
      a = 15'($urandom_range(0, 7)) | 15'h4000;
      access_checked(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
    end

    // write straight after read: turnaround must avoid contention
    access_checked(1'b0, 15'h0000, 8'h00);
    access_checked(1'b1, 15'h0001, 8'hC3);
    access_checked(1'b0, 15'h0001, 8'h00);

    repeat (3) @(negedge clk);
    check(req_ready && cs_n && !dq_oe, "R1 quiet after traffic", {req_ready, cs_n, dq_oe}, 6);
    check(addr_viol == 0, "R2 address moved in write overlap", addr_viol, 0);
    check(oe_viol == 0, "R3 write with output enable low", oe_viol, 0);
    check(time_viol == 0, "R4 R5 pulse or data timing", time_viol, 0);
    check(cont_viol == 0, "R6 bus contention", cont_viol, 0);
    check(idle_viol == 0, "R7 select low while idle", idle_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule